// File: doc/BRIEF.md
# Power-Domain Power-Up Sequencer

The block switches on and off a bank of power domains, one at a time, by moving each domain's control word through a fixed series of steps. A domain is either a general domain or a CPU-core domain, and the kind, chosen with the request, selects which step series runs. Between certain steps the sequencer waits for the power switches, the L1 memory or the SRAM to acknowledge, and each wait is bounded by a cycle limit supplied on an input.

A request carries a domain index, the domain kind and a direction. Power-up follows the step series for that kind. Power-down runs the same series backwards with every value inverted, and each wait still follows the action it belongs to. The control words, the L1 power-down requests and the SRAM power-down requests are outputs held in registers. The acknowledges come back on inputs, one bit per domain.

Top module: `pwr_dom_sequencer`

## Requirements
- R1: Under synchronous active-low reset every domain's control word is 0x32, with reset held (bit 0 low), isolation set (bit 1), both power-on bits (bits 2 and 3) clear, clock disable set (bit 4), SRAM clock isolation set (bit 5) and the active-low SRAM isolation bit (bit 6) low. Every L1 and SRAM power-down request is 1, and busy, done and timeout are 0.
- R2: Bits 2 and 3 of a control word always change together, in the same cycle.
- R3: A general power-up sets bits 2 and 3, then waits for the power acknowledge, clears bit 4, clears bit 1, sets bit 0, clears the SRAM power-down request, and then waits for the SRAM acknowledge to go low. From 0x32 it ends at 0x2D.
- R4: A CPU power-up sets bits 2 and 3, then waits for the power acknowledge, clears bit 1, clears the L1 power-down request, waits for the L1 acknowledge to go low, sets bit 6, clears bit 5, clears bit 4, and sets bit 0 last. From 0x32 it ends at 0x4D.
- R5: The power acknowledge counts as received only while the domain's bit is 1 in both status vectors. In power-down it counts only while both bits are 0.
- R6: Power-down (direction input 0) applies the power-up actions of the chosen kind in reverse order with inverted values. After setting the SRAM or L1 power-down request it waits for that acknowledge to go high, and after clearing bits 2 and 3 it waits for the power acknowledge to drop.
- R7: If an acknowledge wait stays unmet for as many cycles as the timeout input (0 is taken as 1), the sequencer stops, leaves the control word as its last step set it, raises the timeout flag and drops busy. The flag stays high until the next accepted request.
- R8: A request is accepted only while idle and only for an index below the domain count. Requests made while busy have no effect on any domain.
- R9: busy goes high the cycle after a request is accepted. done is high for exactly one cycle, in the cycle busy falls after the last step completes.
- R10: Each step takes at least one clock cycle, so at most one control action reaches the outputs per cycle. While idle the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_up | input | 1 | 1 = power up, 0 = power down |
| req_cpu | input | 1 | 1 = CPU-core step series, 0 = general series |
| req_dom | input | DOM_W | Index of the target domain |
| tmo_limit | input | TMO_W | Cycle bound for each acknowledge wait |
| pwr_ack_a | input | N_DOM | Primary power status, one bit per domain |
| pwr_ack_b | input | N_DOM | Second power status, one bit per domain |
| l1_ack | input | N_DOM | 1 = the domain's L1 memory is powered down |
| sram_ack | input | N_DOM | 1 = the domain's SRAM is powered down |
| dom_ctrl | output | 7*N_DOM | Control words; domain d occupies bits 7d+6..7d |
| l1_pdn | output | N_DOM | L1 power-down requests |
| sram_pdn | output | N_DOM | SRAM power-down requests |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| tmo_err | output | 1 | The last sequence timed out |

## Verification
A scoreboard predicts every change of the domain state, including the power-down requests, for both kinds in both directions and compares it in order. A design that swapped two steps, or changed two fields in one cycle, shows up as a miscompare or an unexpected change. The bench holds back the second status vector alone so that a design accepting the primary acknowledge alone finishes instead of timing out. It freezes all acknowledges to check that the sequence stops at the right step with the flag raised. It also issues a request in the middle of a sequence to catch a design that re-targets or restarts, and checks that done lasts exactly one cycle.

// File: rtl/pds_pkg.sv
// Package: shared field codes, wait codes and the step record used by the
// power-domain sequencer. Assumes a 7-bit control word per domain.
package pds_pkg;

    localparam int CW_W     = 7;
    localparam int B_RSTB   = 0;
    localparam int B_ISO    = 1;
    localparam int B_ON     = 2;
    localparam int B_ON2    = 3;
    localparam int B_CLKDIS = 4;
    localparam int B_SCKISO = 5;
    localparam int B_SISOB  = 6;
    localparam int STEP_W   = 4;

    localparam logic [CW_W-1:0] CW_RESET = 7'b0110010;

    typedef enum logic [3:0] {
        FLD_NONE, FLD_ON, FLD_RSTB, FLD_ISO, FLD_CLKDIS,
        FLD_SCKISO, FLD_SISOB, FLD_L1PDN, FLD_SPDN
    } fld_e;

    typedef enum logic [1:0] {
        WT_NONE, WT_PWR, WT_L1, WT_SRAM
    } wt_e;

    typedef struct packed {
        logic        is_wait;
        fld_e        fld;
        wt_e         wt;
        logic        val;
    } step_t;

    function automatic step_t mk_act(fld_e f, logic v);
        step_t s;
        s.is_wait = 1'b0;
        s.fld     = f;
        s.wt      = WT_NONE;
        s.val     = v;
        return s;
    endfunction

    function automatic step_t mk_wait(wt_e w, logic v);
        step_t s;
        s.is_wait = 1'b1;
        s.fld     = FLD_NONE;
        s.wt      = w;
        s.val     = v;
        return s;
    endfunction

endpackage

// File: rtl/pds_step_rom.sv
// Step table: maps (kind, direction, step index) to one action or wait.
// Assumes step indices start at 0 and that 'last' marks the final entry.
module pds_step_rom
    import pds_pkg::*;
(
    input  logic              is_cpu,
    input  logic              is_up,
    input  logic [STEP_W-1:0] idx,
    output step_t             act,
    output logic              last
);

    // Select the step record for the current sequence position.
    always_comb begin
        act  = mk_wait(WT_NONE, 1'b0);
        last = 1'b0;
        unique case ({is_cpu, is_up})
            2'b01: begin
                last = (idx == 4'd6);
                case (idx)
                    4'd0: act = mk_act(FLD_ON, 1'b1);
                    4'd1: act = mk_wait(WT_PWR, 1'b1);
                    4'd2: act = mk_act(FLD_CLKDIS, 1'b0);
                    4'd3: act = mk_act(FLD_ISO, 1'b0);
                    4'd4: act = mk_act(FLD_RSTB, 1'b1);
                    4'd5: act = mk_act(FLD_SPDN, 1'b0);
                    4'd6: act = mk_wait(WT_SRAM, 1'b0);
                    default: act = mk_wait(WT_NONE, 1'b0);
                endcase
            end
            2'b00: begin
                last = (idx == 4'd6);
                case (idx)
                    4'd0: act = mk_act(FLD_SPDN, 1'b1);
                    4'd1: act = mk_wait(WT_SRAM, 1'b1);
                    4'd2: act = mk_act(FLD_RSTB, 1'b0);
                    4'd3: act = mk_act(FLD_ISO, 1'b1);
                    4'd4: act = mk_act(FLD_CLKDIS, 1'b1);
                    4'd5: act = mk_act(FLD_ON, 1'b0);
                    4'd6: act = mk_wait(WT_PWR, 1'b0);
                    default: act = mk_wait(WT_NONE, 1'b0);
                endcase
            end
            2'b11: begin
                last = (idx == 4'd8);
                case (idx)
                    4'd0: act = mk_act(FLD_ON, 1'b1);
                    4'd1: act = mk_wait(WT_PWR, 1'b1);
                    4'd2: act = mk_act(FLD_ISO, 1'b0);
                    4'd3: act = mk_act(FLD_L1PDN, 1'b0);
                    4'd4: act = mk_wait(WT_L1, 1'b0);
                    4'd5: act = mk_act(FLD_SISOB, 1'b1);
                    4'd6: act = mk_act(FLD_SCKISO, 1'b0);
                    4'd7: act = mk_act(FLD_CLKDIS, 1'b0);
                    4'd8: act = mk_act(FLD_RSTB, 1'b1);
                    default: act = mk_wait(WT_NONE, 1'b0);
                endcase
            end
            default: begin
                last = (idx == 4'd8);
                case (idx)
                    4'd0: act = mk_act(FLD_RSTB, 1'b0);
                    4'd1: act = mk_act(FLD_CLKDIS, 1'b1);
                    4'd2: act = mk_act(FLD_SCKISO, 1'b1);
                    4'd3: act = mk_act(FLD_SISOB, 1'b0);
                    4'd4: act = mk_act(FLD_L1PDN, 1'b1);
                    4'd5: act = mk_wait(WT_L1, 1'b1);
                    4'd6: act = mk_act(FLD_ISO, 1'b1);
                    4'd7: act = mk_act(FLD_ON, 1'b0);
                    4'd8: act = mk_wait(WT_PWR, 1'b0);
                    default: act = mk_wait(WT_NONE, 1'b0);
                endcase
            end
        endcase
    end

endmodule

// File: rtl/pds_ack_eval.sv
// Acknowledge evaluator: decides whether the current wait is satisfied for
// the selected domain. The power wait needs both status vectors to agree.
module pds_ack_eval
    import pds_pkg::*;
#(
    parameter int N_DOM = 4,
    localparam int DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic [DOM_W-1:0] dom,
    input  wt_e              wt,
    input  logic             level,
    input  logic [N_DOM-1:0] pwr_ack_a,
    input  logic [N_DOM-1:0] pwr_ack_b,
    input  logic [N_DOM-1:0] l1_ack,
    input  logic [N_DOM-1:0] sram_ack,
    output logic             met
);

    logic a_bit, b_bit;

    // Pick the selected domain's status bits.
    always_comb begin
        a_bit = pwr_ack_a[dom];
        b_bit = pwr_ack_b[dom];
    end

    // Compare the selected acknowledge against the level the step wants.
    always_comb begin
        unique case (wt)
            WT_PWR:  met = level ? (a_bit & b_bit) : ~(a_bit | b_bit);
            WT_L1:   met = (l1_ack[dom] == level);
            WT_SRAM: met = (sram_ack[dom] == level);
            default: met = 1'b1;
        endcase
    end

endmodule

// File: rtl/pds_wait_timer.sv
// Wait timer: counts unmet cycles of one acknowledge wait and flags the
// cycle in which the bound is reached. A bound of 0 is treated as 1.
module pds_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);

    logic [TMO_W-1:0] cnt;
    logic [TMO_W-1:0] lim_m1;

    // Last count value before expiry.
    always_comb lim_m1 = (limit == '0) ? '0 : (limit - 1'b1);

    // Expiry is reached when this unmet cycle is the bound-th one.
    always_comb expire = run && (cnt >= lim_m1);

    // Count unmet wait cycles; restart whenever no wait is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pds_dom_bank.sv
// Domain register bank: holds every domain's control word and memory
// power-down requests and applies one field write per cycle.
module pds_dom_bank
    import pds_pkg::*;
#(
    parameter int N_DOM = 4,
    localparam int DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DOM_W-1:0]      wr_dom,
    input  fld_e                  wr_fld,
    input  logic                  wr_val,
    output logic [CW_W*N_DOM-1:0] dom_ctrl,
    output logic [N_DOM-1:0]      l1_pdn,
    output logic [N_DOM-1:0]      sram_pdn
);

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        logic [CW_W-1:0] cw_q;
        logic            l1_q;
        logic            sp_q;
        logic            hit;

        // Decode whether this domain is the write target.
        always_comb hit = wr_en && (wr_dom == DOM_W'(d));

        // Update one field of this domain's state on a targeted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cw_q <= CW_RESET;
                l1_q <= 1'b1;
                sp_q <= 1'b1;
            end else if (hit) begin
                unique case (wr_fld)
                    FLD_ON: begin
                        cw_q[B_ON]  <= wr_val;
                        cw_q[B_ON2] <= wr_val;
                    end
                    FLD_RSTB:   cw_q[B_RSTB]   <= wr_val;
                    FLD_ISO:    cw_q[B_ISO]    <= wr_val;
                    FLD_CLKDIS: cw_q[B_CLKDIS] <= wr_val;
                    FLD_SCKISO: cw_q[B_SCKISO] <= wr_val;
                    FLD_SISOB:  cw_q[B_SISOB]  <= wr_val;
                    FLD_L1PDN:  l1_q           <= wr_val;
                    FLD_SPDN:   sp_q           <= wr_val;
                    default: ;
                endcase
            end
        end

        // Drive this domain's slice of the output buses.
        always_comb begin
            dom_ctrl[d*CW_W +: CW_W] = cw_q;
            l1_pdn[d]                = l1_q;
            sram_pdn[d]              = sp_q;
        end
    end

endmodule

// File: rtl/pwr_dom_sequencer.sv
// Power-domain sequencer top: accepts one request at a time, walks the
// step table for the chosen kind and direction, applies one action per
// cycle, bounds each acknowledge wait and reports done or timeout.
module pwr_dom_sequencer
    import pds_pkg::*;
#(
    parameter int N_DOM = 4,
    parameter int TMO_W = 16,
    localparam int DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_up,
    input  logic                  req_cpu,
    input  logic [DOM_W-1:0]      req_dom,
    input  logic [TMO_W-1:0]      tmo_limit,
    input  logic [N_DOM-1:0]      pwr_ack_a,
    input  logic [N_DOM-1:0]      pwr_ack_b,
    input  logic [N_DOM-1:0]      l1_ack,
    input  logic [N_DOM-1:0]      sram_ack,
    output logic [CW_W*N_DOM-1:0] dom_ctrl,
    output logic [N_DOM-1:0]      l1_pdn,
    output logic [N_DOM-1:0]      sram_pdn,
    output logic                  busy,
    output logic                  done,
    output logic                  tmo_err
);

    logic [DOM_W-1:0]  dom_q;
    logic              up_q;
    logic              cpu_q;
    logic [STEP_W-1:0] step_q;
    step_t             act;
    logic              last;
    logic              met;
    logic              wait_run;
    logic              expire;
    logic              dom_ok;
    logic              advance;

    pds_step_rom u_rom (
        .is_cpu (cpu_q),
        .is_up  (up_q),
        .idx    (step_q),
        .act    (act),
        .last   (last)
    );

    pds_ack_eval #(.N_DOM(N_DOM)) u_ack (
        .dom       (dom_q),
        .wt        (act.wt),
        .level     (act.val),
        .pwr_ack_a (pwr_ack_a),
        .pwr_ack_b (pwr_ack_b),
        .l1_ack    (l1_ack),
        .sram_ack  (sram_ack),
        .met       (met)
    );

    pds_wait_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wait_run),
        .limit  (tmo_limit),
        .expire (expire)
    );

    pds_dom_bank #(.N_DOM(N_DOM)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (busy && !act.is_wait),
        .wr_dom   (dom_q),
        .wr_fld   (act.fld),
        .wr_val   (act.val),
        .dom_ctrl (dom_ctrl),
        .l1_pdn   (l1_pdn),
        .sram_pdn (sram_pdn)
    );

    // Validate the requested index against the domain count.
    always_comb dom_ok = ({1'b0, req_dom} < (DOM_W+1)'(N_DOM));

    // Classify the current step: a pending wait or a step that finishes now.
    always_comb begin
        wait_run = busy && act.is_wait && !met;
        advance  = busy && (!act.is_wait || met);
    end

    // Sequence control: accept, step, finish or abort on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            tmo_err <= 1'b0;
            dom_q   <= '0;
            up_q    <= 1'b0;
            cpu_q   <= 1'b0;
            step_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (req_valid && dom_ok) begin
                    busy    <= 1'b1;
                    tmo_err <= 1'b0;
                    dom_q   <= req_dom;
                    up_q    <= req_up;
                    cpu_q   <= req_cpu;
                    step_q  <= '0;
                end
            end else if (advance) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else if (expire) begin
                busy    <= 1'b0;
                tmo_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwr_dom_sequencer_chk.sv
// Checker: temporal properties of the sequencer outputs, bound to the top.
module pwr_dom_sequencer_chk
    import pds_pkg::*;
#(
    parameter int N_DOM = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [CW_W*N_DOM-1:0] dom_ctrl,
    input logic [N_DOM-1:0]      l1_pdn,
    input logic [N_DOM-1:0]      sram_pdn,
    input logic                  busy,
    input logic                  done,
    input logic                  tmo_err
);

    logic [CW_W*N_DOM-1:0] ctrl_prev;
    logic [N_DOM-1:0]      l1_prev, sp_prev, chg;
    logic                  primed;

    // Remember last cycle's outputs to detect per-domain changes.
    always_ff @(posedge clk) begin
        ctrl_prev <= dom_ctrl;
        l1_prev   <= l1_pdn;
        sp_prev   <= sram_pdn;
        primed    <= rst_n;
    end

    for (genvar d = 0; d < N_DOM; d++) begin : g_chk
        always_comb chg[d] = (dom_ctrl[d*CW_W +: CW_W] != ctrl_prev[d*CW_W +: CW_W])
                           || (l1_pdn[d] != l1_prev[d]) || (sram_pdn[d] != sp_prev[d]);

        assert_on_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
            dom_ctrl[d*CW_W + B_ON] == dom_ctrl[d*CW_W + B_ON2]);

        assert_rst_after_iso_R3: assert property (@(posedge clk) disable iff (!rst_n)
            dom_ctrl[d*CW_W + B_RSTB] |-> !dom_ctrl[d*CW_W + B_ISO]);

        assert_rst_after_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
            dom_ctrl[d*CW_W + B_RSTB] |-> !dom_ctrl[d*CW_W + B_CLKDIS]);
    end

    assert_one_change_R10: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $countones(chg) <= 1);

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(dom_ctrl) && $stable(l1_pdn) && $stable(sram_pdn)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !tmo_err));

    assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> !busy);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !$fell(busy)) |-> !done || !busy);

endmodule

bind pwr_dom_sequencer pwr_dom_sequencer_chk #(.N_DOM(N_DOM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .dom_ctrl  (dom_ctrl),
    .l1_pdn    (l1_pdn),
    .sram_pdn  (sram_pdn),
    .busy      (busy),
    .done      (done),
    .tmo_err   (tmo_err)
);

// File: tb/pwr_dom_sequencer_bench.sv
// Scoreboard bench: driver tasks push predicted per-domain state changes,
// a monitor pops and compares them as the outputs change.
module pwr_dom_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_up = 1'b0, req_cpu = 1'b0;
    logic [1:0]    req_dom = '0;
    logic [TW-1:0] tmo_limit = 16'd40;
    logic [N-1:0]  pwr_a, pwr_b, l1_ack, sram_ack;
    logic [7*N-1:0] dom_ctrl;
    logic [N-1:0]  l1_pdn, sram_pdn;
    logic          busy, done, tmo_err;

    int n_vec = 0, n_bad = 0;
    logic [N-1:0] freeze = '0, kill_b = '0;
    logic [N-1:0] pa1, pa2, pa3, la1, la2, la3, sa1, sa2, sa3;
    logic [10:0] expq [$];
    logic [8:0]  st   [N];
    logic [8:0]  seen [N];
    logic        mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_dom_sequencer #(.N_DOM(N), .TMO_W(TW)) u_pwr_dom_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_up(req_up),
        .req_cpu(req_cpu), .req_dom(req_dom), .tmo_limit(tmo_limit),
        .pwr_ack_a(pwr_a), .pwr_ack_b(pwr_b), .l1_ack(l1_ack), .sram_ack(sram_ack),
        .dom_ctrl(dom_ctrl), .l1_pdn(l1_pdn), .sram_pdn(sram_pdn),
        .busy(busy), .done(done), .tmo_err(tmo_err));

    // Plant model: acknowledges follow the requests three cycles later.
    always @(posedge clk) begin
        for (int d = 0; d < N; d++) begin
            if (!freeze[d]) begin
                pa1[d] <= dom_ctrl[7*d+2] & dom_ctrl[7*d+3];
                la1[d] <= l1_pdn[d];
                sa1[d] <= sram_pdn[d];
            end
        end
        pa2 <= pa1; pa3 <= pa2;
        la2 <= la1; la3 <= la2;
        sa2 <= sa1; sa3 <= sa2;
    end
    initial begin
        pa1 = '0; pa2 = '0; pa3 = '0;
        la1 = '1; la2 = '1; la3 = '1;
        sa1 = '1; sa2 = '1; sa3 = '1;
    end
    assign pwr_a    = pa3;
    assign pwr_b    = pa3 & ~kill_b;
    assign l1_ack   = la3;
    assign sram_ack = sa3;

    function automatic logic [8:0] snap(int d);
        return {sram_pdn[d], l1_pdn[d], dom_ctrl[7*d +: 7]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every observed per-domain change must match the queue head.
    always @(negedge clk) begin
        if (mon_on) begin
            for (int d = 0; d < N; d++) begin
                if (snap(d) !== seen[d]) begin
                    if (expq.size() == 0) begin
                        check("R8 unexpected change", {d[1:0], snap(d)}, 32'h0);
                    end else begin
                        logic [10:0] e;
                        e = expq.pop_front();
                        check("R3/R4/R6 step order", {d[1:0], snap(d)}, e);
                    end
                    seen[d] = snap(d);
                end
            end
        end
    end

    // Driver helper: predict one field update, queue it if the state moves.
    task automatic stp(int d, logic [8:0] set_m, logic [8:0] clr_m);
        logic [8:0] nx;
        nx = (st[d] & ~clr_m) | set_m;
        if (nx != st[d]) expq.push_back({d[1:0], nx});
        st[d] = nx;
    endtask

    task automatic predict(int d, bit cpu, bit up);
        if (!cpu && up) begin
            stp(d, 9'h00C, 0); stp(d, 0, 9'h010); stp(d, 0, 9'h002);
            stp(d, 9'h001, 0); stp(d, 0, 9'h100);
        end else if (cpu && up) begin
            stp(d, 9'h00C, 0); stp(d, 0, 9'h002); stp(d, 0, 9'h080);
            stp(d, 9'h040, 0); stp(d, 0, 9'h020); stp(d, 0, 9'h010);
            stp(d, 9'h001, 0);
        end else if (!cpu) begin
            stp(d, 9'h100, 0); stp(d, 0, 9'h001); stp(d, 9'h002, 0);
            stp(d, 9'h010, 0); stp(d, 0, 9'h00C);
        end else begin
            stp(d, 0, 9'h001); stp(d, 9'h010, 0); stp(d, 9'h020, 0);
            stp(d, 0, 9'h040); stp(d, 9'h080, 0); stp(d, 9'h002, 0);
            stp(d, 0, 9'h00C);
        end
    endtask

    task automatic issue(int d, bit cpu, bit up);
        @(negedge clk);
        req_valid = 1'b1; req_dom = d[1:0]; req_cpu = cpu; req_up = up;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Wait for busy to fall; report done and timeout seen on that cycle.
    task automatic finish_wait(output bit d_seen, output bit e_seen);
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        d_seen = done; e_seen = tmo_err;
    endtask

    initial begin
        bit dn, er;
        for (int d = 0; d < N; d++) begin st[d] = 9'h1B2; seen[d] = 9'h1B2; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int d = 0; d < N; d++) check("R1 reset word", snap(d), 9'h1B2);
        check("R1 flags", {busy, done, tmo_err}, 3'b000);
        mon_on = 1'b1;

        // R3 general power-up with R9 busy/done timing
        predict(0, 0, 1);
        issue(0, 0, 1);
        check("R9 busy after accept", busy, 1'b1);
        // R8 request while busy must not touch domain 2
        issue(2, 1, 1);
        finish_wait(dn, er);
        check("R9 done with busy fall", {dn, er}, 2'b10);
        @(negedge clk);
        check("R9 done one cycle", done, 1'b0);
        check("R3 final word", dom_ctrl[6:0], 7'h2D);
        check("R8 ignored domain", snap(2), 9'h1B2);
        check("R8 queue drained", expq.size(), 0);
        repeat (3) @(negedge clk);

        // R4 CPU power-up
        predict(1, 1, 1);
        issue(1, 1, 1);
        finish_wait(dn, er);
        check("R4 done", {dn, er}, 2'b10);
        check("R4 final word", dom_ctrl[13:7], 7'h4D);
        check("R4 l1 released", l1_pdn[1], 1'b0);
        repeat (3) @(negedge clk);

        // R6 general power-down
        predict(0, 0, 0);
        issue(0, 0, 0);
        finish_wait(dn, er);
        check("R6 general down done", {dn, er}, 2'b10);
        check("R6 general down word", snap(0), 9'h1B2);
        repeat (3) @(negedge clk);

        // R6 CPU power-down
        predict(1, 1, 0);
        issue(1, 1, 0);
        finish_wait(dn, er);
        check("R6 cpu down done", {dn, er}, 2'b10);
        check("R6 cpu down word", snap(1), 9'h1B2);
        check("R6 queue drained", expq.size(), 0);

        // R7 timeout: acknowledges frozen for domain 3
        freeze[3] = 1'b1; tmo_limit = 16'd5;
        stp(3, 9'h00C, 0);
        issue(3, 0, 1);
        finish_wait(dn, er);
        check("R7 timeout flags", {dn, er}, 2'b01);
        check("R7 word left at last step", snap(3), 9'h1BE);
        @(negedge clk);
        check("R7 flag sticky", tmo_err, 1'b1);

        // R5 only primary status present: must still time out
        tmo_limit = 16'd12; kill_b[2] = 1'b1;
        stp(2, 9'h00C, 0);
        issue(2, 1, 1);
        check("R7 flag cleared on accept", tmo_err, 1'b0);
        finish_wait(dn, er);
        check("R5 second vector required", {dn, er}, 2'b01);

        // R5 second vector restored: same domain completes
        kill_b[2] = 1'b0;
        predict(2, 1, 1);
        issue(2, 1, 1);
        finish_wait(dn, er);
        check("R5 both vectors accepted", {dn, er}, 2'b10);
        check("R5 final word", dom_ctrl[20:14], 7'h4D);
        repeat (3) @(negedge clk);
        check("R10 idle queue drained", expq.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule